// File: doc/BRIEF.md
# Paced Energy Pulse Output FIFO

This block takes the pulse-level updates that an energy-computation engine produces for two meter outputs, one carrying real energy and one carrying reactive energy. The engine writes a burst of updates once per multiplexer frame, typically six per channel. Each channel stores its burst in a small FIFO and replays the levels one by one, with a programmable spacing between them. This spreads the frame's pulse activity evenly in time instead of bunching it at the moment the engine computes it.

A per-channel width limiter watches how many consecutive low levels have been released. When the output has been low for longer than a limit taken from a register, it forces the output high. A two-bit select field can steer either channel's pulse to an optical transmit pin. A frame-sync strobe restarts the pacing so that the first update of every frame goes out at once.

Top module: `pulse_pacer_top`

## Requirements
- R1: After a synchronous active-high reset, both pulse outputs are 1, both overflow flags are 0 and both FIFOs are empty.
- R2: With a nonzero `interval`, a channel holding a backlog releases its updates exactly 4 × `interval` clock cycles apart. When the pacing timer is idle, a newly written update is released on the second clock edge after its write strobe.
- R3: With `interval` = 0, no pacing delay is added. The level written on one edge appears on the output after the next edge, and back-to-back writes appear on back-to-back cycles.
- R4: Each channel FIFO holds 8 updates and replays them in write order. A write that arrives while 8 updates are held is dropped and sets that channel's overflow flag, which stays 1 until reset.
- R5: A cycle with `frame_sync` = 1 releases the FIFO head on that clock edge even when the pacing timer is still running, and the timer restarts from that release.
- R6: The output is forced high once the number of consecutive released low updates would exceed 2 × `max_width` + 1. Further low updates keep it high until a high update has been released. The next low update after that drives the output low again.
- R7: When the FIFO is empty, or between paced releases, the output holds the last released level.
- R8: `opt_tx` follows `opt_sel`: 2'b00 gives 1, 2'b01 gives `pulse_real`, 2'b10 gives `pulse_react`, and 2'b11 gives 1.
- R9: The two channels are independent copies of the same logic. Writes, overflow and pacing on one channel do not change the other channel's output or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Filter-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_sync | input | 1 | Multiplexer frame start strobe |
| wr_real | input | 1 | Write strobe, real-energy channel |
| lvl_real | input | 1 | Update level, real-energy channel |
| wr_react | input | 1 | Write strobe, reactive-energy channel |
| lvl_react | input | 1 | Update level, reactive-energy channel |
| interval | input | IVL_W | Pacing interval; spacing is 4 × interval cycles |
| max_width | input | MW_W | Low-width limit code; limit is 2 × code + 1 updates |
| opt_sel | input | 2 | Optical transmit source select |
| pulse_real | output | 1 | Real-energy pulse output |
| pulse_react | output | 1 | Reactive-energy pulse output |
| opt_tx | output | 1 | Optical transmit output |
| ovf_real | output | 1 | Sticky overflow, real-energy channel |
| ovf_react | output | 1 | Sticky overflow, reactive-energy channel |

## Verification
The spacing check assumes that `interval` stays constant between two releases. It rearms after any change of `interval` or any frame-sync strobe. The low-run check assumes that `max_width` does not shrink while a low run is in progress. The bench therefore changes `interval` and `max_width` only while a channel is idle or in reset, and it asserts `frame_sync` only when it is testing the early release.

// File: rtl/pp_pkg.sv
`timescale 1ns/1ps
package pp_pkg;
   localparam int NCH      = 2;
   localparam int CH_REAL  = 0;
   localparam int CH_REACT = 1;

   typedef enum logic [1:0] {
      OPT_IDLE  = 2'b00,
      OPT_REAL  = 2'b01,
      OPT_REACT = 2'b10,
      OPT_RSVD  = 2'b11
   } opt_sel_e;
endpackage

// File: rtl/pp_fifo.sv
`timescale 1ns/1ps
module pp_fifo #(
   parameter int DEPTH = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic push,
   input  logic din,
   input  logic pop,
   output logic dout,
   output logic empty,
   output logic full
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = AW + 1;

   logic [DEPTH-1:0] mem;
   logic [AW-1:0]    wp, rp;
   logic [CW-1:0]    cnt;
   logic             push_ok, pop_ok;

   assign empty   = (cnt == '0);
   assign full    = (cnt == CW'(DEPTH));
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign dout    = mem[rp];

   always_ff @(posedge clk) begin
      if (rst) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
         mem <= '0;
      end else begin
         if (push_ok) begin
            mem[wp] <= din;
            wp      <= wp + AW'(1);
         end
         if (pop_ok) rp <= rp + AW'(1);
         case ({push_ok, pop_ok})
            2'b10:   cnt <= cnt + CW'(1);
            2'b01:   cnt <= cnt - CW'(1);
            default: cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/pp_chan.sv
`timescale 1ns/1ps
module pp_chan #(
   parameter int DEPTH = 8,
   parameter int IVL_W = 8,
   parameter int MW_W  = 8,
   parameter int MULT  = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             sync,
   input  logic             wr,
   input  logic             lvl,
   input  logic [IVL_W-1:0] interval,
   input  logic [MW_W-1:0]  max_width,
   output logic             pulse,
   output logic             ovf,
   output logic             rel
);
   localparam int MUL_W = $clog2(MULT) + 1;
   localparam int TMR_W = IVL_W + MUL_W;
   localparam int LIM_W = MW_W + 1;
   localparam int CNT_W = MW_W + 2;

   logic             head, empty, full, ivl_zero;
   logic [TMR_W-1:0] period, tmr;
   logic [LIM_W-1:0] limit;
   logic [CNT_W-1:0] lowcnt, cnt_inc;
   logic             forced;

   pp_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst(rst), .push(wr), .din(lvl), .pop(rel),
      .dout(head), .empty(empty), .full(full)
   );

   // pacing period: shift when the multiplier is a power of two
   if ((MULT & (MULT - 1)) == 0) begin : g_shift
      assign period = TMR_W'(interval) << $clog2(MULT);
   end else begin : g_mul
      assign period = TMR_W'(interval) * TMR_W'(MULT);
   end

   assign ivl_zero = (interval == '0);
   assign rel      = !empty && (ivl_zero || sync || (tmr == '0));

   always_ff @(posedge clk) begin
      if (rst)                tmr <= '0;
      else if (rel)           tmr <= ivl_zero ? '0 : period - TMR_W'(1);
      else if (sync)          tmr <= '0;
      else if (tmr != '0)     tmr <= tmr - TMR_W'(1);
   end

   always_ff @(posedge clk) begin
      if (rst)             ovf <= 1'b0;
      else if (wr && full) ovf <= 1'b1;
   end

   // width limiter counts released low updates
   assign limit   = {max_width, 1'b1};
   assign cnt_inc = (lowcnt == '1) ? lowcnt : lowcnt + CNT_W'(1);

   always_ff @(posedge clk) begin
      if (rst) begin
         pulse  <= 1'b1;
         lowcnt <= '0;
         forced <= 1'b0;
      end else if (rel) begin
         if (head) begin
            pulse  <= 1'b1;
            lowcnt <= '0;
            forced <= 1'b0;
         end else if (forced) begin
            pulse  <= 1'b1;
         end else if (cnt_inc > CNT_W'(limit)) begin
            pulse  <= 1'b1;
            lowcnt <= '0;
            forced <= 1'b1;
         end else begin
            pulse  <= 1'b0;
            lowcnt <= cnt_inc;
         end
      end
   end
endmodule

// File: rtl/pp_optmux.sv
`timescale 1ns/1ps
module pp_optmux
   import pp_pkg::*;
(
   input  logic [1:0] sel,
   input  logic       p_in,
   input  logic       q_in,
   output logic       tx
);
   always_comb begin
      case (opt_sel_e'(sel))
         OPT_REAL:  tx = p_in;
         OPT_REACT: tx = q_in;
         default:   tx = 1'b1;
      endcase
   end
endmodule

// File: rtl/pulse_pacer_top.sv
`timescale 1ns/1ps
module pulse_pacer_top
   import pp_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int IVL_W = 8,
   parameter int MW_W  = 8,
   parameter int MULT  = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             frame_sync,
   input  logic             wr_real,
   input  logic             lvl_real,
   input  logic             wr_react,
   input  logic             lvl_react,
   input  logic [IVL_W-1:0] interval,
   input  logic [MW_W-1:0]  max_width,
   input  logic [1:0]       opt_sel,
   output logic             pulse_real,
   output logic             pulse_react,
   output logic             opt_tx,
   output logic             ovf_real,
   output logic             ovf_react
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("pulse_pacer_top: DEPTH must be a power of two of at least 2");
   end
   if (MULT < 1) begin : g_bad_mult
      $error("pulse_pacer_top: MULT must be at least 1");
   end
   if (IVL_W < 1 || MW_W < 1) begin : g_bad_width
      $error("pulse_pacer_top: register widths must be at least 1");
   end

   logic [NCH-1:0] wr_v, lvl_v, pulse_v, ovf_v, rel_v;

   assign wr_v  = {wr_react, wr_real};
   assign lvl_v = {lvl_react, lvl_real};

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      pp_chan #(.DEPTH(DEPTH), .IVL_W(IVL_W), .MW_W(MW_W), .MULT(MULT)) u_chan (
         .clk(clk), .rst(rst), .sync(frame_sync),
         .wr(wr_v[c]), .lvl(lvl_v[c]),
         .interval(interval), .max_width(max_width),
         .pulse(pulse_v[c]), .ovf(ovf_v[c]), .rel(rel_v[c])
      );
   end

   assign pulse_real  = pulse_v[CH_REAL];
   assign pulse_react = pulse_v[CH_REACT];
   assign ovf_real    = ovf_v[CH_REAL];
   assign ovf_react   = ovf_v[CH_REACT];

   pp_optmux u_optmux (
      .sel(opt_sel), .p_in(pulse_v[CH_REAL]), .q_in(pulse_v[CH_REACT]), .tx(opt_tx)
   );
endmodule

// File: rtl/pp_checker.sv
`timescale 1ns/1ps
module pp_checker #(
   parameter int IVL_W = 8,
   parameter int MW_W  = 8,
   parameter int MULT  = 4
) (
   input logic             clk,
   input logic             rst,
   input logic             frame_sync,
   input logic [IVL_W-1:0] interval,
   input logic [MW_W-1:0]  max_width,
   input logic             pulse_real,
   input logic             pulse_react,
   input logic             ovf_real,
   input logic             ovf_react,
   input logic             rel_real,
   input logic             rel_react
);
   logic [15:0]      gap;
   logic             seen;
   logic [IVL_W-1:0] ivl_q;
   logic             rel_d;
   logic [MW_W+1:0]  lowrun;

   always_ff @(posedge clk) begin
      if (rst) begin
         gap    <= '0;
         seen   <= 1'b0;
         ivl_q  <= '0;
         rel_d  <= 1'b0;
         lowrun <= '0;
      end else begin
         ivl_q <= interval;
         rel_d <= rel_real;
         if (rel_real)        gap <= '0;
         else if (gap != '1)  gap <= gap + 16'd1;
         if (frame_sync || interval != ivl_q) seen <= 1'b0;
         else if (rel_real)                   seen <= 1'b1;
         if (rel_d) lowrun <= pulse_real ? '0 : lowrun + 1'b1;
      end
   end

   // R1: outputs high and flags clear after reset
   a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (pulse_real && pulse_react && !ovf_real && !ovf_react));

   // R2: paced releases keep the programmed spacing
   a_r2_spacing: assert property (@(posedge clk) disable iff (rst)
      (rel_real && seen && !frame_sync && interval != '0 && interval == ivl_q)
      |-> (32'(gap) + 1 >= 32'(interval) * MULT));

   // R4: overflow flags are sticky
   a_r4_ovf_sticky_real: assert property (@(posedge clk) disable iff (rst)
      ovf_real |=> ovf_real);
   a_r4_ovf_sticky_react: assert property (@(posedge clk) disable iff (rst)
      ovf_react |=> ovf_react);

   // R6: a low run never exceeds the limit
   a_r6_low_limit: assert property (@(posedge clk) disable iff (rst)
      32'(lowrun) <= 2 * 32'(max_width) + 1);

   // R7: outputs change only on a release
   a_r7_hold_real: assert property (@(posedge clk) disable iff (rst)
      !rel_real |=> $stable(pulse_real));
   a_r7_hold_react: assert property (@(posedge clk) disable iff (rst)
      !rel_react |=> $stable(pulse_react));
endmodule

bind pulse_pacer_top pp_checker #(.IVL_W(IVL_W), .MW_W(MW_W), .MULT(MULT)) u_chk (
   .clk(clk), .rst(rst), .frame_sync(frame_sync),
   .interval(interval), .max_width(max_width),
   .pulse_real(pulse_real), .pulse_react(pulse_react),
   .ovf_real(ovf_real), .ovf_react(ovf_react),
   .rel_real(rel_v[0]), .rel_react(rel_v[1])
);

// File: tb/test_pulse_pacer_top.sv
`timescale 1ns/1ps
module test_pulse_pacer_top;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       frame_sync = 1'b0;
   logic       wr_real = 1'b0, lvl_real = 1'b0, wr_react = 1'b0, lvl_react = 1'b0;
   logic [7:0] interval = 8'd0;
   logic [7:0] max_width = 8'd255;
   logic [1:0] opt_sel = 2'b00;
   logic       pulse_real, pulse_react, opt_tx, ovf_real, ovf_react;

   always #2 clk = ~clk;

   pulse_pacer_top i_pulse_pacer_top (
      .clk(clk), .rst(rst), .frame_sync(frame_sync),
      .wr_real(wr_real), .lvl_real(lvl_real),
      .wr_react(wr_react), .lvl_react(lvl_react),
      .interval(interval), .max_width(max_width), .opt_sel(opt_sel),
      .pulse_real(pulse_real), .pulse_react(pulse_react), .opt_tx(opt_tx),
      .ovf_real(ovf_real), .ovf_react(ovf_react)
   );

   int checks = 0, fails = 0, cyc = 0, log_n = 0;
   int   log_cyc [16];
   logic log_lvl [16];
   logic prev_p = 1'b1;

   always @(posedge clk) cyc++;

   always @(negedge clk) begin
      if (pulse_real !== prev_p) begin
         if (log_n < 16) begin
            log_cyc[log_n] = cyc;
            log_lvl[log_n] = pulse_real;
         end
         log_n++;
      end
      prev_p = pulse_real;
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst = 1'b1; wr_real = 1'b0; wr_react = 1'b0; frame_sync = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
   endtask

   // write n levels on one channel, check the output two edges later
   task automatic stream(input bit ch, input int n, input logic [15:0] din,
                         input logic [15:0] exp, input string req);
      for (int i = 0; i < n + 2; i++) begin
         if (i >= 2) chk(req, ch ? int'(pulse_react) : int'(pulse_real), int'(exp[i-2]));
         if (i < n) begin
            if (ch) begin wr_react = 1'b1; lvl_react = din[i]; end
            else    begin wr_real  = 1'b1; lvl_real  = din[i]; end
         end else begin
            wr_real = 1'b0; wr_react = 1'b0;
         end
         @(negedge clk);
      end
   endtask

   task automatic t_reset_state();
      interval = 8'd0; max_width = 8'd255; opt_sel = 2'b00;
      do_reset();
      chk("R1 pulse_real after reset", int'(pulse_real), 1);
      chk("R1 pulse_react after reset", int'(pulse_react), 1);
      chk("R1 ovf_real after reset", int'(ovf_real), 0);
      chk("R1 ovf_react after reset", int'(ovf_react), 0);
   endtask

   task automatic t_zero_interval();
      interval = 8'd0; max_width = 8'd255;
      stream(1'b0, 6, 16'b010110, 16'b010110, "R3 unpaced stream");
   endtask

   task automatic t_pacing();
      logic lv [6] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
      int c0;
      interval = 8'd2; max_width = 8'd255;
      do_reset();
      log_n = 0;
      c0 = cyc;
      for (int i = 0; i < 6; i++) begin
         wr_real = 1'b1; lvl_real = lv[i];
         @(negedge clk);
      end
      wr_real = 1'b0;
      repeat (50) @(negedge clk);
      chk("R2 release count", log_n, 6);
      chk("R2 first release latency", log_cyc[0] - c0, 2);
      chk("R4 first level", int'(log_lvl[0]), int'(lv[0]));
      for (int i = 1; i < 6; i++) begin
         chk("R2 release spacing", log_cyc[i] - log_cyc[i-1], 8);
         chk("R4 replay order", int'(log_lvl[i]), int'(lv[i]));
      end
   endtask

   task automatic t_frame_sync();
      interval = 8'd50;
      @(negedge clk);
      log_n = 0;
      wr_real = 1'b1; lvl_real = 1'b0;
      @(negedge clk);
      lvl_real = 1'b1;
      @(negedge clk);
      wr_real = 1'b0;
      repeat (20) @(negedge clk);
      chk("R7 held while pacing", int'(pulse_real), 0);
      frame_sync = 1'b1;
      @(negedge clk);
      frame_sync = 1'b0;
      chk("R5 release on frame sync", int'(pulse_real), 1);
      repeat (40) @(negedge clk);
      chk("R7 held when empty", int'(pulse_real), 1);
      chk("R7 no extra changes", log_n, 2);
   endtask

   task automatic t_overflow();
      interval = 8'd255; max_width = 8'd255;
      do_reset();
      for (int i = 0; i < 12; i++) begin
         wr_real = 1'b1; lvl_real = i[0];
         @(negedge clk);
      end
      wr_real = 1'b0;
      @(negedge clk);
      chk("R4 overflow flag set", int'(ovf_real), 1);
      chk("R9 other overflow clear", int'(ovf_react), 0);
      chk("R9 other output untouched", int'(pulse_react), 1);
      repeat (5) @(negedge clk);
      chk("R4 overflow sticky", int'(ovf_real), 1);
      log_n = 0;
      interval = 8'd0;
      repeat (12) @(negedge clk);
      chk("R4 stored entries drained", log_n, 8);
      chk("R4 last stored level", int'(pulse_real), 0);
      do_reset();
      chk("R1 reset clears overflow", int'(ovf_real), 0);
      chk("R1 reset sets output", int'(pulse_real), 1);
   endtask

   task automatic t_width();
      interval = 8'd0;
      max_width = 8'd1;
      stream(1'b0, 8, 16'b01000001, 16'b01110001, "R6 limit 3");
      max_width = 8'd0;
      stream(1'b0, 5, 16'b01001, 16'b01101, "R6 limit 1");
      max_width = 8'd255;
   endtask

   task automatic t_react();
      logic keep;
      interval = 8'd0;
      keep = pulse_real;
      stream(1'b1, 3, 16'b010, 16'b010, "R9 reactive stream");
      chk("R9 real output unchanged", int'(pulse_real), int'(keep));
   endtask

   task automatic sel_sweep(input string req);
      int e;
      for (int s = 0; s < 4; s++) begin
         opt_sel = 2'(s);
         #1;
         case (s)
            1:       e = int'(pulse_real);
            2:       e = int'(pulse_react);
            default: e = 1;
         endcase
         chk(req, int'(opt_tx), e);
      end
      opt_sel = 2'b00;
   endtask

   task automatic t_optsel();
      interval = 8'd0; max_width = 8'd255;
      stream(1'b0, 1, 16'b0, 16'b0, "R8 setup real low");
      stream(1'b1, 1, 16'b0, 16'b0, "R8 setup react low");
      sel_sweep("R8 both low");
      stream(1'b0, 1, 16'b1, 16'b1, "R8 setup real high");
      sel_sweep("R8 real high");
      stream(1'b0, 1, 16'b0, 16'b0, "R8 setup real low again");
      stream(1'b1, 1, 16'b1, 16'b1, "R8 setup react high");
      sel_sweep("R8 react high");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset_state();
      t_zero_interval();
      t_pacing();
      t_frame_sync();
      t_overflow();
      t_width();
      t_react();
      t_optsel();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule